// File: doc/BRIEF.md
# XOR Parity Descriptor Sequencer

This block takes one complete 128-byte work descriptor and turns it into a stream of source requests for a downstream read-and-accumulate engine. It decodes the control word, checks whether the descriptor is an XOR parity job it can run, and then issues one request per source buffer. Each request carries a 48-bit source address, the byte length and the 48-bit destination address. The final request is marked so that the engine writes the accumulated parity to the destination.

Source addresses are packed in groups of three 32-bit words. Each group holds two sources: the low word of the even source, then the low word of the odd source, then one word that carries both 16-bit high parts. The sequencer rebuilds each full address from this packing. Every descriptor ends with a single-cycle completion pulse. The pulse carries the descriptor tag, an error flag and the interrupt-on-completion request. Descriptors for any other operation are retired as no-ops without issuing requests.

The descriptor is presented as a 1024-bit vector, with 32-bit word w in bits [32w+31:32w]. The words used are:

| Word | Contents |
|------|----------|
| 0 | Tag in [15:0] |
| 2 | Control word |
| 3 | Byte length |
| 6 | Destination address, low 32 bits |
| 7 | Destination address, high 16 bits in [15:0] |
| 8 to 19 | Source buffer address words |

Top module: `xor_desc_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `desc_ready` is 1, `src_valid` is 0 and `done_valid` is 0.
- R2: A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both 1. `desc_ready` then stays 0 until the cycle after the completion pulse.
- R3: The operation code is control bits [31:28], and only value 6 means XOR. Any other code retires the descriptor without issuing requests and with `done_err`=0. The completion pulse comes in the cycle right after acceptance.
- R4: An XOR descriptor is runnable when its source count (control bits [26:22]) is between 1 and 8 and its parity-output enable (control bit 17) is 1. A runnable descriptor issues exactly count requests with `src_idx` 0, 1, ..., count-1. The first request appears in the cycle after acceptance, and the sequencer advances on each `src_valid`&&`src_ready`. While `src_ready` is 0, the request stays unchanged. Control bit 16 (second-parity enable) has no effect.
- R5: For source i, let k = i/2. The low 32 bits come from buffer word 3k + (i mod 2). The high 16 bits come from buffer word 3k+2: bits [15:0] for even i and bits [31:16] for odd i.
- R6: `src_len` equals descriptor word 3. `dst_addr` equals {word 7 [15:0], word 6}.
- R7: `src_last` is 1 exactly on the request with index count-1.
- R8: An XOR descriptor with a count of 0 or more than 8, or with control bit 17 at 0, issues no requests. It completes in the cycle after acceptance with `done_err`=1.
- R9: `done_irq` equals control bit 27 on every completion, including no-op and error completions.
- R10: `done_id` equals descriptor word 0 bits [15:0].
- R11: `done_valid` is a one-cycle pulse. For a runnable descriptor, it comes in the cycle after the handshake of the last request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Sequencer idle and able to take a descriptor |
| desc_data | input | 1024 | Full descriptor, word w in bits [32w+31:32w] |
| src_valid | output | 1 | Source request valid |
| src_ready | input | 1 | Downstream engine takes the request |
| src_addr | output | 48 | Source buffer address |
| src_len | output | 32 | Byte length of the operation |
| dst_addr | output | 48 | Destination address |
| src_idx | output | 3 | Index of the current source |
| src_last | output | 1 | Final source: write the parity result |
| done_valid | output | 1 | Completion pulse |
| done_err | output | 1 | Descriptor was rejected |
| done_irq | output | 1 | Interrupt on completion requested |
| done_id | output | 16 | Tag of the completed descriptor |

## Verification
XOR jobs are run with 1, 3, 5 and 8 sources. The odd counts end on an even index and the even counts end on an odd index. This shows whether the half-word selection and the group stepping are correct at both ends. Some addresses have all-ones upper halves next to all-zeros ones, so swapped or shifted high parts become visible. Unused words are filled with random data, and the second-parity bit is set on some jobs, to show that neither reaches the outputs. Downstream readiness runs either always high or randomly throttled, which separates correct holding from a sequencer that advances on valid alone. Counts of 0, 9 and 31, a missing parity enable, a no-op and other operation codes each exercise the immediate-retire path. The error flag and interrupt flag are checked separately on that path.

// File: rtl/xds_pkg.sv
package xds_pkg;
  localparam int DESC_W    = 1024;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 48;
  localparam int ID_WORD   = 0;
  localparam int CTRL_WORD = 2;
  localparam int LEN_WORD  = 3;
  localparam int DLO_WORD  = 6;
  localparam int DHI_WORD  = 7;
  localparam int BUF_WORD  = 8;
  localparam int OP_LSB    = 28;
  localparam int CNT_LSB   = 22;
  localparam int CNT_W     = 5;
  localparam int IRQ_BIT   = 27;
  localparam int PEN_BIT   = 17;
  localparam logic [3:0] OP_XOR = 4'd6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic             run;
    logic             err;
    logic             irq;
    logic [CNT_W-1:0] count;
  } ctrl_dec_t;
endpackage

// File: rtl/xds_decode.sv
module xds_decode
  import xds_pkg::*;
#(
  parameter int MAX_SRC = 8
) (
  input  logic [WORD_W-1:0] ctrl,
  output ctrl_dec_t         dec
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_SRC);

  logic             is_xor;
  logic [CNT_W-1:0] cnt;
  logic             cnt_ok;
  logic             unused_ctrl;

  assign is_xor = (ctrl[OP_LSB +: 4] == OP_XOR);
  assign cnt    = ctrl[CNT_LSB +: CNT_W];
  assign cnt_ok = (cnt != '0) && (cnt <= MAX_CNT);

  // second-parity enable and the low control bits are deliberately ignored
  assign unused_ctrl = ^{ctrl[21:18], ctrl[16:0]};

  always_comb begin
    dec.run   = is_xor && cnt_ok && ctrl[PEN_BIT];
    dec.err   = is_xor && !(cnt_ok && ctrl[PEN_BIT]);
    dec.irq   = ctrl[IRQ_BIT];
    dec.count = cnt;
  end
endmodule

// File: rtl/xds_unpack.sv
module xds_unpack
  import xds_pkg::*;
#(
  parameter int MAX_SRC = 8,
  localparam int IDX_W  = $clog2(MAX_SRC),
  localparam int NWORDS = 3 * (MAX_SRC / 2)
) (
  input  logic [NWORDS*WORD_W-1:0] words,
  input  logic [IDX_W-1:0]         idx,
  output logic [ADDR_W-1:0]        addr
);
  logic [ADDR_W-1:0] cand [MAX_SRC];

  for (genvar i = 0; i < MAX_SRC; i++) begin : g_src
    localparam int LO_W  = 3 * (i / 2) + (i % 2);
    localparam int HI_W  = 3 * (i / 2) + 2;
    localparam int HI_SH = 16 * (i % 2);
    assign cand[i] = {words[HI_W*WORD_W + HI_SH +: 16],
                      words[LO_W*WORD_W +: WORD_W]};
  end

  assign addr = cand[idx];
endmodule

// File: rtl/xds_ctrl.sv
module xds_ctrl
  import xds_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  input  logic             run,
  input  logic             src_ready,
  input  logic [IDX_W-1:0] last_idx,
  output logic             desc_ready,
  output logic             load,
  output logic             src_valid,
  output logic             src_last,
  output logic             done_valid,
  output logic [IDX_W-1:0] src_idx
);
  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    idx_en     = 1'b0;
    desc_ready = 1'b0;
    load       = 1'b0;
    src_valid  = 1'b0;
    done_valid = 1'b0;
    src_last   = (idx_q == last_idx);
    unique case (state_q)
      ST_IDLE: begin
        desc_ready = 1'b1;
        if (desc_valid) begin
          load    = 1'b1;
          idx_en  = 1'b1;
          idx_d   = '0;
          state_d = run ? ST_EMIT : ST_DONE;
        end
      end
      ST_EMIT: begin
        src_valid = 1'b1;
        if (src_ready) begin
          if (src_last) begin
            state_d = ST_DONE;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 1'b1;
          end
        end
      end
      ST_DONE: begin
        done_valid = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign src_idx = idx_q;
endmodule

// File: rtl/xor_desc_seq.sv
module xor_desc_seq
  import xds_pkg::*;
#(
  parameter int MAX_SRC = 8,
  localparam int IDX_W    = $clog2(MAX_SRC),
  localparam int NWORDS   = 3 * (MAX_SRC / 2),
  localparam int BUF_BITS = NWORDS * WORD_W,
  localparam int BUF_LO   = BUF_WORD * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                desc_valid,
  output logic                desc_ready,
  input  logic [DESC_W-1:0]   desc_data,
  output logic                src_valid,
  input  logic                src_ready,
  output logic [ADDR_W-1:0]   src_addr,
  output logic [WORD_W-1:0]   src_len,
  output logic [ADDR_W-1:0]   dst_addr,
  output logic [IDX_W-1:0]    src_idx,
  output logic                src_last,
  output logic                done_valid,
  output logic                done_err,
  output logic                done_irq,
  output logic [15:0]         done_id
);
  ctrl_dec_t          dec;
  logic               load;
  logic [BUF_BITS-1:0] bufw_q;
  logic [WORD_W-1:0]  len_q;
  logic [ADDR_W-1:0]  dst_q;
  logic [15:0]        id_q;
  logic               err_q, irq_q;
  logic [IDX_W-1:0]   last_q;
  logic               unused_desc;

  assign unused_desc = ^{desc_data[31:16], desc_data[63:32],
                         desc_data[191:128], desc_data[255:240],
                         desc_data[DESC_W-1:BUF_LO+BUF_BITS]};

  xds_decode #(.MAX_SRC(MAX_SRC)) u_decode (
    .ctrl (desc_data[CTRL_WORD*WORD_W +: WORD_W]),
    .dec  (dec)
  );

  // descriptor capture, enabled only on acceptance
  always_ff @(posedge clk) begin
    if (load) begin
      bufw_q <= desc_data[BUF_LO +: BUF_BITS];
      len_q  <= desc_data[LEN_WORD*WORD_W +: WORD_W];
      dst_q  <= {desc_data[DHI_WORD*WORD_W +: 16],
                 desc_data[DLO_WORD*WORD_W +: WORD_W]};
      id_q   <= desc_data[ID_WORD*WORD_W +: 16];
      err_q  <= dec.err;
      irq_q  <= dec.irq;
      last_q <= IDX_W'(dec.count - 1'b1);
    end
  end

  xds_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .run        (dec.run),
    .src_ready  (src_ready),
    .last_idx   (last_q),
    .desc_ready (desc_ready),
    .load       (load),
    .src_valid  (src_valid),
    .src_last   (src_last),
    .done_valid (done_valid),
    .src_idx    (src_idx)
  );

  xds_unpack #(.MAX_SRC(MAX_SRC)) u_unpack (
    .words (bufw_q),
    .idx   (src_idx),
    .addr  (src_addr)
  );

  assign src_len  = len_q;
  assign dst_addr = dst_q;
  assign done_err = err_q;
  assign done_irq = irq_q;
  assign done_id  = id_q;
endmodule

// File: rtl/xor_desc_seq_chk.sv
module xor_desc_seq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic             src_valid,
  input logic             src_ready,
  input logic [47:0]      src_addr,
  input logic [IDX_W-1:0] src_idx,
  input logic             src_last,
  input logic             done_valid,
  input logic             done_err
);
  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_ready |=> !desc_ready);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid || done_valid) |-> !desc_ready);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && !src_ready |=> src_valid && $stable(src_addr) && $stable(src_idx));

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && !src_last |=>
      src_valid && (src_idx == IDX_W'($past(src_idx) + 1'b1)));

  assert_last_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && src_ready && src_last |=> done_valid);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && desc_ready);

  assert_err_no_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err |-> !src_valid);
endmodule

bind xor_desc_seq xor_desc_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .desc_valid (desc_valid),
  .desc_ready (desc_ready),
  .src_valid  (src_valid),
  .src_ready  (src_ready),
  .src_addr   (src_addr),
  .src_idx    (src_idx),
  .src_last   (src_last),
  .done_valid (done_valid),
  .done_err   (done_err)
);

// File: tb/xor_desc_seq_bench.sv
`timescale 1ns/1ps
module xor_desc_seq_bench;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          desc_valid;
  logic          desc_ready;
  logic [1023:0] desc_data;
  logic          src_valid;
  logic          src_ready;
  logic [47:0]   src_addr;
  logic [31:0]   src_len;
  logic [47:0]   dst_addr;
  logic [2:0]    src_idx;
  logic          src_last;
  logic          done_valid;
  logic          done_err;
  logic          done_irq;
  logic [15:0]   done_id;

  always #2.5 clk = ~clk;

  xor_desc_seq u_xor_desc_seq (.*);

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit finished = 0;
  int rmode = 0;

  // pending descriptor expectations, set by the driver before desc_valid
  logic [47:0] p_addr [8];
  logic [3:0]  p_mode;
  int          p_cnt;
  bit          p_pen, p_irq;
  logic [15:0] p_id;
  logic [31:0] p_len;
  logic [47:0] p_dst;

  // reference model state
  logic [47:0] q_addr [$];
  int          q_idx  [$];
  bit          m_ready = 1;
  bit          exp_done = 0;
  bit          e_err, e_irq;
  logic [15:0] e_id;
  logic [31:0] e_len;
  logic [47:0] e_dst;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1;
    src_ready <= (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  always @(negedge clk) begin
    bit nxt_done;
    if (rst_n && !finished) begin
      if (exp_done) begin
        check(done_valid === 1'b1, "R11 done pulse", done_valid, 1);
        check(done_err === e_err, "R8 error flag", done_err, e_err);
        check(done_irq === e_irq, "R9 irq flag", done_irq, e_irq);
        check(done_id === e_id, "R10 tag", done_id, e_id);
      end else begin
        check(done_valid === 1'b0, "R11 no pulse", done_valid, 0);
      end
      check(desc_ready === m_ready, "R2 ready", desc_ready, m_ready);
      if (q_addr.size() > 0) begin
        check(src_valid === 1'b1, "R4 request valid", src_valid, 1);
        check(src_idx === 3'(q_idx[0]), "R4 index order", src_idx, q_idx[0]);
        check(src_addr === q_addr[0], "R5 source address", src_addr, q_addr[0]);
        check(src_last === (q_addr.size() == 1), "R7 last flag", src_last,
              q_addr.size() == 1);
        check(src_len === e_len, "R6 length", src_len, e_len);
        check(dst_addr === e_dst, "R6 destination", dst_addr, e_dst);
      end else begin
        check(src_valid === 1'b0, "R3 no request", src_valid, 0);
      end
      nxt_done = 0;
      if (exp_done) m_ready = 1;
      if (desc_valid && m_ready) begin
        m_ready = 0;
        e_irq = p_irq;
        e_id  = p_id;
        e_len = p_len;
        e_dst = p_dst;
        e_err = (p_mode == 4'd6) && !(p_cnt >= 1 && p_cnt <= 8 && p_pen);
        if (p_mode == 4'd6 && !e_err) begin
          for (int i = 0; i < p_cnt; i++) begin
            q_addr.push_back(p_addr[i]);
            q_idx.push_back(i);
          end
        end else begin
          nxt_done = 1;
        end
      end else if (q_addr.size() > 0 && src_valid && src_ready) begin
        void'(q_addr.pop_front());
        void'(q_idx.pop_front());
        if (q_addr.size() == 0) nxt_done = 1;
      end
      exp_done = nxt_done;
    end
  end

  task automatic send(input logic [15:0] id, input logic [3:0] mode, input int cnt,
                      input bit pen, input bit qen, input bit irq,
                      input logic [31:0] len, input logic [47:0] dst);
    logic [1023:0] d;
    for (int w = 0; w < 32; w++) d[32*w +: 32] = $urandom;
    d[15:0]    = id;
    d[95:64]   = {mode, irq, 5'(cnt), 4'b0, pen, qen, 16'hA5C3};
    d[127:96]  = len;
    d[223:192] = dst[31:0];
    d[239:224] = dst[47:32];
    for (int i = 0; i < 8; i++) begin
      d[32*(8 + 3*(i/2) + (i%2)) +: 32]       = p_addr[i][31:0];
      d[32*(8 + 3*(i/2) + 2) + 16*(i%2) +: 16] = p_addr[i][47:32];
    end
    p_mode = mode; p_cnt = cnt; p_pen = pen; p_irq = irq;
    p_id = id; p_len = len; p_dst = dst;
    desc_data  = d;
    desc_valid = 1'b1;
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #1;
    desc_valid = 1'b0;
    do @(negedge clk); while (!desc_ready);
    @(posedge clk); #1;
  endtask

  task automatic rand_addrs();
    for (int i = 0; i < 8; i++) p_addr[i] = {$urandom, $urandom};
  endtask

  initial begin
    rst_n = 1'b0;
    desc_valid = 1'b0;
    desc_data = '0;
    src_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(desc_ready === 1'b1, "R1 reset ready", desc_ready, 1);
    check(src_valid === 1'b0, "R1 reset valid", src_valid, 0);
    check(done_valid === 1'b0, "R1 reset done", done_valid, 0);
    @(posedge clk); #1;

    // R4 R5: eight sources, high halves alternate all-ones and zero
    for (int i = 0; i < 8; i++)
      p_addr[i] = (i % 2) ? {16'hFFFF, 32'h1000_0000 + i} : {16'h0000, 32'hFFFF_FFF0 - i};
    send(16'h0101, 4'd6, 8, 1, 0, 1, 32'd4096, 48'h1234_5678_9ABC);
    rand_addrs();
    send(16'h0202, 4'd6, 1, 1, 0, 0, 32'd64, 48'hFFFF_0000_0001);
    rmode = 1;
    rand_addrs();
    send(16'h0303, 4'd6, 3, 1, 0, 1, 32'd512, 48'h0000_DEAD_BEEF);
    rand_addrs(); // R4: second-parity bit set, no effect
    send(16'h0404, 4'd6, 5, 1, 1, 0, 32'd128, 48'h8000_0000_0000);
    // R3 R9: no-op and other codes
    send(16'h0505, 4'd0, 2, 1, 0, 1, 32'd1, 48'h1);
    send(16'h0606, 4'd1, 4, 1, 0, 0, 32'd2, 48'h2);
    send(16'h0707, 4'd7, 4, 1, 1, 1, 32'd3, 48'h3);
    // R8: rejected XOR jobs
    send(16'h0808, 4'd6, 0, 1, 0, 1, 32'd4, 48'h4);
    send(16'h0909, 4'd6, 9, 1, 0, 0, 32'd5, 48'h5);
    send(16'h0A0A, 4'd6, 31, 1, 0, 1, 32'd6, 48'h6);
    send(16'h0B0B, 4'd6, 4, 0, 0, 1, 32'd7, 48'h7);
    for (int n = 0; n < 60; n++) begin
      int c;
      logic [3:0] m;
      rand_addrs();
      rmode = n % 2;
      m = (($urandom % 4) != 0) ? 4'd6 : 4'($urandom);
      c = (($urandom % 6) != 0) ? 1 + ($urandom % 8) : ($urandom % 32);
      send(16'($urandom), m, c, ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
           $urandom, {$urandom, $urandom});
    end
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule